// File: doc/BRIEF.md
# Phase-Dimming Reference State Controller

This block sets the current reference of a phase-dimmable LED driver. Once per slot it receives a line measurement: a slot tick (256 slots per line period), a strobe on the falling edge of the line-sense signal, the live sense level, the normalized conduction length of the line cycle, a flag for duty above 70%, and a flag for a lost sense signal. A supply-ready enable from undervoltage lockout starts or stops it. Its output is a 7-bit reference code from 0 to 127, which maps linearly onto 0 to 1 V at an external DAC.

Four states decide the code: start-up, non-dimming, dimming and signal-lost. The start-up state is left after a measurement window of `STARTUP_FALLS` falling strobes. After that, each falling strobe selects the next state from the two flags. The one exception is a lost signal, which moves the block to signal-lost on the next clock edge.

While dimming, the block outputs a DC code that follows the conduction length. While non-dimming, it outputs a triangular ramp centred on code 55. The ramp is shaped only while the sense input is high. The ramp amplitude grows over `RAMP_CYCLES` line cycles on entry to non-dimming and shrinks by the same steps on exit, so the output never jumps from DC to full ramp.

Top module: `phase_ref_ctrl`

## Requirements
- R1: While `uvlo_ok` is low (or `rst_n` is low), the state is start-up, the ramp amplitude is cleared and `ref_code` is 50.
- R2: After `uvlo_ok` rises, `ref_code` stays 50 until the `STARTUP_FALLS`-th (default 4) `line_fall` strobe. At that strobe the state becomes signal-lost if `sig_lost` is high, non-dimming if `duty_hi` is high, and dimming otherwise.
- R3: Outside start-up, a high `sig_lost` makes the state signal-lost at the next clock edge, even without a strobe. In that state `ref_code` is 42 and the ramp amplitude is cleared.
- R4: Apart from entry into signal-lost, a state change happens only on a clock edge where `line_fall` is high. Between strobes, changes in `duty_hi` have no effect on `ref_code`.
- R5: In dimming with zero amplitude, `ref_code` equals the conduction length latched at the last strobe plus `DIM_OFS` (default -116, which puts length 179 at code 63), clamped to the range 35 to 63.
- R6: In non-dimming, with amplitude a (0 to 8), the ramp has peak 55 + floor(72·a/8) and trough 55 − floor(33·a/8). At full amplitude these are 127 and 22. While sense is high, each slot tick moves the ramp up by 2, capped at the peak, while the slot index since the sense rise is below half the latched length. After that, each slot tick moves it down by 2, floored at the trough.
- R7: The ramp restarts at the trough on each rising edge of `sense_hi`. While the registered sense level is low, the ramp output is the trough.
- R8: At each strobe outside start-up, the amplitude goes up by one (saturating at `RAMP_CYCLES`) if the new state is non-dimming, and down by one (saturating at 0) otherwise. In dimming with nonzero amplitude, `ref_code` is the ramp output, not the DC code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uvlo_ok | input | 1 | Supply above lockout threshold; low holds start-up |
| slot_tick | input | 1 | One pulse per line slot (256 per period) |
| line_fall | input | 1 | Strobe on the falling edge of line sense |
| sense_hi | input | 1 | Live line-sense level, high while conducting |
| cond_len | input | 8 | Normalized conduction length in slots |
| duty_hi | input | 1 | Line duty above 70% |
| sig_lost | input | 1 | Line-sense signal lost |
| ref_code | output | 7 | Reference code, 0 to 127 for 0 to 1 V |

## Verification
The assertions check these properties on every cycle: the fixed codes in start-up and signal-lost, the 35-to-63 window in settled dimming, the ramp floor in non-dimming, immediate entry into signal-lost, state changes only at a strobe, and amplitude moving by one step only at a strobe. Only the bench scenarios can show the exact ramp waveform against the latched conduction length, the eight-cycle fade into and out of the ramp, the offset and clamping of the dimming code, and recovery after a lockout drop. The bench compares a behavioural model against `ref_code` on every clock.

// File: rtl/phase_ref_pkg.sv
package phase_ref_pkg;
    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_NODIM = 2'd1,
        ST_DIM   = 2'd2,
        ST_LOST  = 2'd3
    } ctl_state_t;

    localparam int CODE_START = 50;
    localparam int CODE_LOST  = 42;
    localparam int DIM_MIN    = 35;
    localparam int DIM_MAX    = 63;
    localparam int RAMP_MID   = 55;
    localparam int RAMP_LO    = 22;
    localparam int RAMP_HI    = 127;
    localparam int RAMP_STEP  = 2;
endpackage

// File: rtl/ref_ctl_fsm.sv
module ref_ctl_fsm
    import phase_ref_pkg::*;
#(
    parameter int STARTUP_FALLS = 4,
    parameter int RAMP_CYCLES   = 8,
    localparam int CW = $clog2(STARTUP_FALLS + 1),
    localparam int AW = $clog2(RAMP_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          uvlo_ok,
    input  logic          line_fall,
    input  logic          duty_hi,
    input  logic          sig_lost,
    output ctl_state_t    state,
    output logic [AW-1:0] amp
);
    ctl_state_t    st_q, st_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic [AW-1:0] amp_q, amp_n;
    ctl_state_t    pick;

    always_comb begin
        if (sig_lost)     pick = ST_LOST;
        else if (duty_hi) pick = ST_NODIM;
        else              pick = ST_DIM;
    end

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        amp_n = amp_q;
        unique case (st_q)
            ST_START: begin
                if (line_fall) begin
                    if (int'(cnt_q) == STARTUP_FALLS - 1) st_n = pick;
                    else                                  cnt_n = cnt_q + 1'b1;
                end
            end
            ST_NODIM, ST_DIM, ST_LOST: begin
                if (sig_lost)       st_n = ST_LOST;
                else if (line_fall) st_n = pick;
            end
            default: st_n = ST_START;
        endcase
        if (st_n == ST_LOST) begin
            amp_n = '0;
        end else if (line_fall && st_n != ST_START) begin
            if (st_n == ST_NODIM) begin
                if (int'(amp_q) < RAMP_CYCLES) amp_n = amp_q + 1'b1;
            end else if (amp_q != '0) begin
                amp_n = amp_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_START;
            cnt_q <= '0;
            amp_q <= '0;
        end else if (!uvlo_ok) begin
            st_q  <= ST_START;
            cnt_q <= '0;
            amp_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            amp_q <= amp_n;
        end
    end

    assign state = st_q;
    assign amp   = amp_q;
endmodule

// File: rtl/ref_ramp_gen.sv
module ref_ramp_gen
    import phase_ref_pkg::*;
#(
    parameter int RAMP_CYCLES = 8,
    parameter int LEN_W       = 8,
    localparam int AW    = $clog2(RAMP_CYCLES + 1),
    localparam int POS_MAX = (1 << LEN_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uvlo_ok,
    input  logic             slot_tick,
    input  logic             sense_hi,
    input  logic [LEN_W-1:0] len_q,
    input  logic [AW-1:0]    amp,
    output logic [6:0]       ramp_code
);
    logic             sense_q;
    logic [LEN_W-1:0] pos_q;
    logic [7:0]       val_q;
    int               peak, trough, val_n, shown;

    always_comb begin
        peak   = RAMP_MID + ((RAMP_HI - RAMP_MID) * int'(amp)) / RAMP_CYCLES;
        trough = RAMP_MID - ((RAMP_MID - RAMP_LO) * int'(amp)) / RAMP_CYCLES;
        if (int'(pos_q) < int'(len_q >> 1)) begin
            val_n = int'(val_q) + RAMP_STEP;
            if (val_n > peak) val_n = peak;
        end else begin
            val_n = int'(val_q) - RAMP_STEP;
            if (val_n < trough) val_n = trough;
        end
        shown = int'(val_q);
        if (shown > peak)   shown = peak;
        if (shown < trough) shown = trough;
        if (!sense_q)       shown = trough;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense_q <= 1'b0;
            pos_q   <= '0;
            val_q   <= 8'(RAMP_MID);
        end else if (!uvlo_ok) begin
            sense_q <= 1'b0;
            pos_q   <= '0;
            val_q   <= 8'(RAMP_MID);
        end else begin
            sense_q <= sense_hi;
            if (sense_hi && !sense_q) begin
                pos_q <= '0;
                val_q <= 8'(trough);
            end else if (slot_tick && sense_hi) begin
                if (int'(pos_q) != POS_MAX) pos_q <= pos_q + 1'b1;
                val_q <= 8'(val_n);
            end
        end
    end

    assign ramp_code = 7'(shown);
endmodule

// File: rtl/ref_dim_map.sv
module ref_dim_map
    import phase_ref_pkg::*;
#(
    parameter int LEN_W   = 8,
    parameter int DIM_OFS = -116
) (
    input  logic [LEN_W-1:0] len_q,
    output logic [6:0]       dim_code
);
    int sum;

    always_comb begin
        sum = int'(len_q) + DIM_OFS;
        if (sum < DIM_MIN) sum = DIM_MIN;
        if (sum > DIM_MAX) sum = DIM_MAX;
        dim_code = 7'(sum);
    end
endmodule

// File: rtl/phase_ref_ctrl.sv
module phase_ref_ctrl
    import phase_ref_pkg::*;
#(
    parameter int STARTUP_FALLS = 4,
    parameter int RAMP_CYCLES   = 8,
    parameter int LEN_W         = 8,
    parameter int DIM_OFS       = -116,
    localparam int AW = $clog2(RAMP_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uvlo_ok,
    input  logic             slot_tick,
    input  logic             line_fall,
    input  logic             sense_hi,
    input  logic [LEN_W-1:0] cond_len,
    input  logic             duty_hi,
    input  logic             sig_lost,
    output logic [6:0]       ref_code
);
    ctl_state_t       st_q;
    logic [AW-1:0]    amp_q;
    logic [LEN_W-1:0] len_q;
    logic [6:0]       ramp_code;
    logic [6:0]       dim_code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          len_q <= '0;
        else if (!uvlo_ok)   len_q <= '0;
        else if (line_fall)  len_q <= cond_len;
    end

    ref_ctl_fsm #(.STARTUP_FALLS(STARTUP_FALLS), .RAMP_CYCLES(RAMP_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .uvlo_ok(uvlo_ok), .line_fall(line_fall),
        .duty_hi(duty_hi), .sig_lost(sig_lost), .state(st_q), .amp(amp_q)
    );

    ref_ramp_gen #(.RAMP_CYCLES(RAMP_CYCLES), .LEN_W(LEN_W)) u_ramp (
        .clk(clk), .rst_n(rst_n), .uvlo_ok(uvlo_ok), .slot_tick(slot_tick),
        .sense_hi(sense_hi), .len_q(len_q), .amp(amp_q), .ramp_code(ramp_code)
    );

    ref_dim_map #(.LEN_W(LEN_W), .DIM_OFS(DIM_OFS)) u_dim (
        .len_q(len_q), .dim_code(dim_code)
    );

    always_comb begin
        unique case (st_q)
            ST_START: ref_code = 7'(CODE_START);
            ST_LOST:  ref_code = 7'(CODE_LOST);
            ST_NODIM: ref_code = ramp_code;
            ST_DIM:   ref_code = (amp_q != '0) ? ramp_code : dim_code;
            default:  ref_code = 7'(CODE_START);
        endcase
    end
endmodule

// File: rtl/phase_ref_ctrl_chk.sv
module phase_ref_ctrl_chk
    import phase_ref_pkg::*;
#(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          uvlo_ok,
    input logic          line_fall,
    input logic          sig_lost,
    input logic [6:0]    ref_code,
    input ctl_state_t    state,
    input logic [AW-1:0] amp
);
    logic started;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    p_uvlo_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !uvlo_ok |=> (state == ST_START && amp == '0));

    p_start_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_START |-> ref_code == 7'(CODE_START));

    p_lost_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (uvlo_ok && sig_lost && state != ST_START) |=> (state == ST_LOST && ref_code == 7'(CODE_LOST) && amp == '0));

    p_strobe_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (started && $past(uvlo_ok) && state != $past(state) && state != ST_LOST) |-> $past(line_fall));

    p_dim_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DIM && amp == '0) |-> (int'(ref_code) >= DIM_MIN && int'(ref_code) <= DIM_MAX));

    p_ramp_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_NODIM |-> int'(ref_code) >= RAMP_LO);

    p_amp_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (started && $past(uvlo_ok) && amp != $past(amp) && amp != '0)
            |-> ($past(line_fall) && (int'(amp) == int'($past(amp)) + 1 || int'(amp) == int'($past(amp)) - 1)));
endmodule

bind phase_ref_ctrl phase_ref_ctrl_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .uvlo_ok(uvlo_ok), .line_fall(line_fall),
    .sig_lost(sig_lost), .ref_code(ref_code), .state(st_q), .amp(amp_q)
);

// File: tb/phase_ref_ctrl_test.sv
module phase_ref_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NFALLS = 4;
    localparam int NRAMP  = 8;
    localparam int OFS    = -116;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       uvlo_ok = 1'b0;
    logic       slot_tick = 1'b0;
    logic       line_fall = 1'b0;
    logic       sense_hi = 1'b0;
    logic [7:0] cond_len = 8'd0;
    logic       duty_hi = 1'b0;
    logic       sig_lost = 1'b0;
    logic [6:0] ref_code;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    phase_ref_ctrl uut (
        .clk(clk), .rst_n(rst_n), .uvlo_ok(uvlo_ok), .slot_tick(slot_tick),
        .line_fall(line_fall), .sense_hi(sense_hi), .cond_len(cond_len),
        .duty_hi(duty_hi), .sig_lost(sig_lost), .ref_code(ref_code)
    );

    // behavioural model: 0 start, 1 non-dimming, 2 dimming, 3 lost
    int m_st, m_cnt, m_amp, m_len, m_sq, m_pos, m_val;
    string m_tag;

    function automatic int pk(int a); return 55 + (72 * a) / NRAMP; endfunction
    function automatic int tr(int a); return 55 - (33 * a) / NRAMP; endfunction

    function automatic int expect_code();
        int v;
        if (m_st == 0) return 50;
        if (m_st == 3) return 42;
        if (m_st == 2 && m_amp == 0) begin
            v = m_len + OFS;
            if (v < 35) v = 35;
            if (v > 63) v = 63;
            return v;
        end
        if (m_sq == 0) return tr(m_amp);
        v = m_val;
        if (v > pk(m_amp)) v = pk(m_amp);
        if (v < tr(m_amp)) v = tr(m_amp);
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n || !uvlo_ok) begin
            m_st = 0; m_cnt = 0; m_amp = 0; m_len = 0; m_sq = 0; m_pos = 0; m_val = 55;
        end else begin
            int tgt, nst, nv;
            tgt = sig_lost ? 3 : (duty_hi ? 1 : 2);
            nst = m_st;
            if (m_st == 0) begin
                if (line_fall) begin
                    if (m_cnt == NFALLS - 1) nst = tgt;
                    else m_cnt++;
                end
            end else if (sig_lost) nst = 3;
            else if (line_fall) nst = tgt;
            // ramp uses amplitude from before this edge
            if (sense_hi && m_sq == 0) begin
                m_pos = 0; m_val = tr(m_amp);
            end else if (slot_tick && sense_hi) begin
                if (m_pos < m_len / 2) begin
                    nv = m_val + 2; if (nv > pk(m_amp)) nv = pk(m_amp);
                end else begin
                    nv = m_val - 2; if (nv < tr(m_amp)) nv = tr(m_amp);
                end
                if (m_pos < 255) m_pos++;
                m_val = nv;
            end
            m_sq = sense_hi ? 1 : 0;
            if (nst == 3) m_amp = 0;
            else if (line_fall && nst != 0) begin
                if (nst == 1) begin if (m_amp < NRAMP) m_amp++; end
                else if (m_amp > 0) m_amp--;
            end
            if (line_fall) m_len = int'(cond_len);
            m_st = nst;
        end
        if (!uvlo_ok || !rst_n) m_tag = "R1";
        else if (m_st == 0) m_tag = "R2";
        else if (m_st == 3) m_tag = "R3";
        else if ((m_st == 1) != (duty_hi == 1'b1)) m_tag = "R4";
        else if (m_st == 2 && m_amp > 0) m_tag = "R8";
        else if (m_st == 2) m_tag = "R5";
        else if (m_sq == 0) m_tag = "R7";
        else m_tag = "R6";
    end

    task automatic cyc();
        @(negedge clk);
        cycles++;
        n_cmp++;
        if (int'(ref_code) !== expect_code()) begin
            n_bad++;
            $display("FAIL %s t=%0t ref_code actual=%0d expected=%0d", m_tag, $time, ref_code, expect_code());
        end
    endtask

    // one line period: 256 slots, conduction in the last cond slots, strobe at slot 0
    task automatic line(int cond, int lost_from);
        for (int s = 0; s < 256; s++) begin
            slot_tick = 1'b1;
            line_fall = (s == 0);
            sense_hi  = (s >= 256 - cond);
            cond_len  = 8'(cond);
            duty_hi   = (cond > 179);
            sig_lost  = (s >= lost_from);
            cyc();
        end
    endtask

    initial begin
        repeat (3) cyc();           // R1 reset state
        rst_n = 1'b1;
        repeat (3) cyc();           // R1 lockout held
        uvlo_ok = 1'b1;
        repeat (6) line(200, 999);  // R2 start-up, then R6/R8 fade-in
        repeat (12) line(200, 999); // R6 R7 full ramp
        // R4: duty flag toggles mid-cycle without a strobe
        for (int s = 0; s < 256; s++) begin
            slot_tick = 1'b1; line_fall = (s == 0); sense_hi = (s >= 56);
            cond_len = 8'd200; duty_hi = (s > 100 && s < 140) ? 1'b0 : 1'b1; sig_lost = 1'b0;
            cyc();
        end
        repeat (10) line(150, 999); // R8 fade-out, R5 clamp low
        repeat (2) line(170, 999);  // R5 code 54
        repeat (2) line(179, 999);  // R5 code 63 at the 70% point
        repeat (2) line(60, 999);   // R5 clamp
        line(170, 100);             // R3 mid-cycle loss
        line(170, 0);               // R3 held
        repeat (3) line(200, 999);  // recovery
        uvlo_ok = 1'b0;
        repeat (4) cyc();           // R1 lockout drop
        uvlo_ok = 1'b1;
        repeat (6) line(120, 999);  // R2 restart into dimming
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule